// File: doc/BRIEF.md
# Bidirectional Shift and Rotate Unit

This block shifts or rotates one W-bit operand by a signed amplitude in one pass and reports the new carry together with overflow, negative and zero flags. An operation code selects one of eight treatments: logical shift, arithmetic shift, plain rotate, or rotate through the carry flag, each in a left and a right form. The sign of the amplitude can reverse the direction chosen by the code, so a single opcode covers both directions when the count is computed at run time.

A request is presented with `in_valid`, the operand, the amplitude, the opcode and the incoming carry. The outputs are registered and appear one clock later with `out_valid`. Outputs hold their last value while no request is presented.

Top module: `bishift_unit`

## Requirements
- R1: Opcode 0 (logical left) moves bits toward the MSB, fills vacated low bits with 0, and sets the carry to the last bit pushed out of the MSB.
- R2: Opcode 1 (logical right) moves bits toward the LSB, fills vacated high bits with 0, and sets the carry to the last bit pushed out of the LSB.
- R3: Opcode 3 (arithmetic right) moves bits toward the LSB, copies the original sign bit into every vacated position, and sets the carry to the last bit pushed out of the LSB.
- R4: Opcode 2 (arithmetic left) gives the same result and carry as logical left and raises the overflow flag when the result's MSB differs from the operand's MSB; the overflow flag is 0 for every other effective operation.
- R5: Opcodes 4 and 5 rotate the operand left or right by the amplitude modulo W; the bit wrapped around on the last step is also copied to the carry.
- R6: Opcodes 6 and 7 rotate the (W+1)-bit ring formed by the carry above the operand, left or right, by the amplitude modulo W+1; the carry output is the ring's top bit afterwards.
- R7: A negative amplitude performs the opposite-direction form of the same operation (left and right differ only in opcode bit 0) by the amplitude's magnitude; a reversed arithmetic right is an arithmetic left including its overflow rule.
- R8: A zero amplitude returns the operand and the incoming carry unchanged with overflow 0.
- R9: A shift whose magnitude is W or more yields all fill bits; the carry is the operand's bit 0 (left) or bit W-1 (right) at magnitude exactly W and the fill bit beyond it.
- R10: The zero flag is 1 exactly when the result is all zeros, and the negative flag equals the result's MSB.
- R11: Results and `out_valid` appear on the clock edge after the request; reset clears every output, and outputs hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code, bit 0 selects right |
| amount | input | AW | Signed shift amplitude, two's complement |
| operand | input | W | Value to shift or rotate |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result registered from a request |
| result | output | W | Shifted or rotated value |
| carry_out | output | 1 | New carry flag |
| ovf | output | 1 | Overflow flag from arithmetic left shift |
| neg | output | 1 | Copy of the result MSB |
| zero | output | 1 | Result is all zeros |

## Verification
Random operands are driven through every opcode with amplitudes spanning the full signed range, so positive and negative counts separate the direction logic, and counts of W, W+1 and beyond separate the saturating shifts from the modulo W and modulo W+1 rotates. Directed vectors use a lone set bit and a lone sign bit, which expose fill-bit and carry errors that random data masks. Operands with the sign bit flipping under a one-place left shift separate correct overflow from an overflow stuck low, and zero amplitude with both carry values shows whether the carry passes through untouched.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

   // Operation codes; bit 0 selects the right-going form.
   typedef enum logic [2:0] {
      OP_SHL  = 3'd0,
      OP_SHR  = 3'd1,
      OP_ASHL = 3'd2,
      OP_ASHR = 3'd3,
      OP_ROL  = 3'd4,
      OP_ROR  = 3'd5,
      OP_RCL  = 3'd6,
      OP_RCR  = 3'd7
   } bsh_op_e;

   // Operation family, taken from opcode bits 2:1.
   typedef enum logic [1:0] {
      K_LOGIC = 2'd0,
      K_ARITH = 2'd1,
      K_ROT   = 2'd2,
      K_RCAR  = 2'd3
   } bsh_kind_e;

endpackage

// File: rtl/bsh_amount_decode.sv
module bsh_amount_decode
   import bsh_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic [2:0]    op,
   input  logic [AW-1:0] amount,
   output bsh_kind_e     kind,
   output logic          go_left,
   output logic [AW-1:0] mag,
   output logic          is_zero
);

   logic amt_neg;

   always_comb begin
      amt_neg = amount[AW-1];
      kind    = bsh_kind_e'(op[2:1]);
      // Direction from the opcode, flipped by a negative amplitude.
      go_left = ~op[0] ^ amt_neg;
      // Magnitude; the most negative value maps onto 2**(AW-1).
      mag     = amt_neg ? (~amount + 1'b1) : amount;
      is_zero = (amount == '0);
   end

endmodule

// File: rtl/bsh_core.sv
module bsh_core
   import bsh_pkg::*;
#(
   parameter int W  = 16,
   parameter int AW = 6
) (
   input  bsh_kind_e     kind,
   input  logic          go_left,
   input  logic [AW-1:0] mag,
   input  logic          is_zero,
   input  logic [W-1:0]  operand,
   input  logic          cin,
   output logic [W-1:0]  res,
   output logic          cout,
   output logic          ovf
);

   localparam int unsigned WU  = W;
   localparam int unsigned WRU = W + 1;

   logic [W:0]           shl_t;
   logic [W:0]           shr_t;
   logic signed [W:0]    sar_t;
   logic [2*W-1:0]       rol_t;
   logic [2*W-1:0]       ror_t;
   logic [W:0]           ring;
   logic [2*W+1:0]       rcl_t;
   logic [2*W+1:0]       rcr_t;
   logic [W:0]           ring_out;
   int unsigned          k_rot;
   int unsigned          k_rcar;

   // Candidate results for every family and direction.
   always_comb begin
      k_rot  = 32'(mag) % WU;
      k_rcar = 32'(mag) % WRU;
      shl_t  = {1'b0, operand} << mag;
      shr_t  = {operand, 1'b0} >> mag;
      sar_t  = $signed({operand, 1'b0}) >>> mag;
      rol_t  = {operand, operand} << k_rot;
      ror_t  = {operand, operand} >> k_rot;
      ring   = {cin, operand};
      rcl_t  = {ring, ring} << k_rcar;
      rcr_t  = {ring, ring} >> k_rcar;
      ring_out = go_left ? rcl_t[2*W+1:W+1] : rcr_t[W:0];
   end

   // Selection of the effective operation.
   always_comb begin
      res  = operand;
      cout = cin;
      ovf  = 1'b0;
      if (!is_zero) begin
         unique case (kind)
            K_LOGIC, K_ARITH: begin
               if (go_left) begin
                  res  = shl_t[W-1:0];
                  cout = shl_t[W];
                  ovf  = (kind == K_ARITH) && (shl_t[W-1] != operand[W-1]);
               end else if (kind == K_ARITH) begin
                  res  = sar_t[W:1];
                  cout = sar_t[0];
               end else begin
                  res  = shr_t[W:1];
                  cout = shr_t[0];
               end
            end
            K_ROT: begin
               if (go_left) begin
                  res  = rol_t[2*W-1:W];
                  cout = rol_t[W];
               end else begin
                  res  = ror_t[W-1:0];
                  cout = ror_t[W-1];
               end
            end
            default: begin
               res  = ring_out[W-1:0];
               cout = ring_out[W];
            end
         endcase
      end
   end

   // Overflow may only come from the arithmetic family (R4).
   always_comb begin
      if (ovf) assert (kind == K_ARITH && go_left)
         else $error("p_ovf_source_r4: overflow outside arithmetic left");
   end

endmodule

// File: rtl/bsh_flags.sv
module bsh_flags #(
   parameter int W = 16
) (
   input  logic [W-1:0] res,
   output logic         zero,
   output logic         neg
);

   always_comb begin
      zero = ~|res;
      neg  = res[W-1];
   end

endmodule

// File: rtl/bishift_unit.sv
module bishift_unit
   import bsh_pkg::*;
#(
   parameter int W       = 16,
   parameter int AW      = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [2:0]           op,
   input  logic signed [AW-1:0] amount,
   input  logic [W-1:0]         operand,
   input  logic                 carry_in,
   output logic                 out_valid,
   output logic [W-1:0]         result,
   output logic                 carry_out,
   output logic                 ovf,
   output logic                 neg,
   output logic                 zero
);

   generate
      if (W < 2) begin : g_bad_w
         $error("bishift_unit: W must be at least 2");
      end
      if (AW < 2) begin : g_bad_aw
         $error("bishift_unit: AW must be at least 2");
      end
   endgenerate

   bsh_kind_e     kind;
   logic          go_left;
   logic [AW-1:0] mag;
   logic          is_zero;
   logic [W-1:0]  res_c;
   logic          cout_c;
   logic          ovf_c;
   logic          zero_c;
   logic          neg_c;

   bsh_amount_decode #(.AW(AW)) u_dec (
      .op      (op),
      .amount  (amount),
      .kind    (kind),
      .go_left (go_left),
      .mag     (mag),
      .is_zero (is_zero)
   );

   bsh_core #(.W(W), .AW(AW)) u_core (
      .kind    (kind),
      .go_left (go_left),
      .mag     (mag),
      .is_zero (is_zero),
      .operand (operand),
      .cin     (carry_in),
      .res     (res_c),
      .cout    (cout_c),
      .ovf     (ovf_c)
   );

   bsh_flags #(.W(W)) u_flags (
      .res  (res_c),
      .zero (zero_c),
      .neg  (neg_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               result    <= '0;
               carry_out <= 1'b0;
               ovf       <= 1'b0;
               neg       <= 1'b0;
               zero      <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  result    <= res_c;
                  carry_out <= cout_c;
                  ovf       <= ovf_c;
                  neg       <= neg_c;
                  zero      <= zero_c;
               end
            end
         end

         p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid && $stable(result) && $stable(carry_out));
         p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && amount == '0 |=>
               result == $past(operand) && carry_out == $past(carry_in) && !ovf);
         p_rot_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && op[2:1] == 2'b10 |=>
               $countones(result) == $countones($past(operand)));
         p_ring_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && op[2:1] == 2'b11 |=>
               $countones({carry_out, result}) ==
               $countones({$past(carry_in), $past(operand)}));
         p_no_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && op[2:1] != 2'b01 |=> !ovf);
         p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> !(zero && neg));
      end else begin : g_comb
         always_comb begin
            out_valid = in_valid;
            result    = res_c;
            carry_out = cout_c;
            ovf       = ovf_c;
            neg       = neg_c;
            zero      = zero_c;
         end
      end
   endgenerate

endmodule

// File: tb/bishift_unit_tb.sv
`timescale 1ns/1ps
module bishift_unit_tb;

   localparam int W  = 16;
   localparam int AW = 6;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic [2:0]           op = '0;
   logic signed [AW-1:0] amount = '0;
   logic [W-1:0]         operand = '0;
   logic                 carry_in = 1'b0;
   logic                 out_valid;
   logic [W-1:0]         result;
   logic                 carry_out;
   logic                 ovf;
   logic                 neg;
   logic                 zero;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bishift_unit #(.W(W), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .amount(amount), .operand(operand), .carry_in(carry_in),
      .out_valid(out_valid), .result(result), .carry_out(carry_out),
      .ovf(ovf), .neg(neg), .zero(zero)
   );

   // Step-by-step reference model: one bit position per iteration.
   task automatic model(input int opc, input int amt, input logic [W-1:0] x,
                        input logic c, output logic [W-1:0] r,
                        output logic co, output logic v);
      bit   left;
      int   mag;
      int   fam;
      logic t;
      left = ((opc % 2) == 0) ^ (amt < 0);
      mag  = (amt < 0) ? -amt : amt;
      fam  = opc / 2;
      r = x; co = c; v = 1'b0;
      for (int i = 0; i < mag; i++) begin
         if (left) begin
            t = r[W-1];
            case (fam)
               2:       r = {r[W-2:0], r[W-1]};
               3:       r = {r[W-2:0], co};
               default: r = {r[W-2:0], 1'b0};
            endcase
            co = t;
         end else begin
            t = r[0];
            case (fam)
               1:       r = {r[W-1], r[W-1:1]};
               2:       r = {r[0], r[W-1:1]};
               3:       r = {co, r[W-1:1]};
               default: r = {1'b0, r[W-1:1]};
            endcase
            co = t;
         end
      end
      if (mag != 0 && fam == 1 && left) v = (r[W-1] != x[W-1]);
   endtask

   function automatic string tag_of(int opc, int amt);
      int mag;
      mag = (amt < 0) ? -amt : amt;
      if (amt == 0) return "R8";
      if (opc < 4 && mag >= W) return "R9";
      if (amt < 0) return "R7";
      case (opc)
         0: return "R1";
         1: return "R2";
         2: return "R4";
         3: return "R3";
         4, 5: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic run_vec(input int opc, input int amt, input logic [W-1:0] x,
                          input logic c);
      logic [W-1:0] er;
      logic         ec;
      logic         ev;
      string        tg;
      model(opc, amt, x, c, er, ec, ev);
      tg = tag_of(opc, amt);
      @(negedge clk);
      in_valid = 1'b1;
      op       = 3'(opc);
      amount   = AW'(amt);
      operand  = x;
      carry_in = c;
      @(negedge clk);
      checks++;
      if (!out_valid || result !== er || carry_out !== ec) begin
         errors++;
         $display("FAIL %s op=%0d amt=%0d x=%h: got v=%b r=%h c=%b, expected v=1 r=%h c=%b",
                  tg, opc, amt, x, out_valid, result, carry_out, er, ec);
      end
      checks++;
      if (ovf !== ev) begin
         errors++;
         $display("FAIL R4 op=%0d amt=%0d x=%h: got ovf=%b, expected %b",
                  opc, amt, x, ovf, ev);
      end
      checks++;
      if (zero !== (er == '0) || neg !== er[W-1]) begin
         errors++;
         $display("FAIL R10 r=%h: got z=%b n=%b, expected z=%b n=%b",
                  er, zero, neg, (er == '0), er[W-1]);
      end
   endtask

   initial begin
      logic [W-1:0] held;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== '0 || carry_out !== 1'b0 ||
          ovf !== 1'b0 || zero !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset: got v=%b r=%h c=%b, expected v=0 r=0 c=0",
                  out_valid, result, carry_out);
      end
      rst_n = 1'b1;

      // Directed corner cases.
      run_vec(0, 1, 16'h8001, 1'b0);     // R1 carry from MSB
      run_vec(1, 1, 16'h8001, 1'b0);     // R2 carry from LSB
      run_vec(3, 4, 16'h8000, 1'b0);     // R3 sign fill
      run_vec(2, 1, 16'h4000, 1'b0);     // R4 sign changes
      run_vec(2, 1, 16'h2000, 1'b0);     // R4 sign kept
      run_vec(4, 17, 16'h8001, 1'b0);    // R5 modulo W
      run_vec(5, 16, 16'h0001, 1'b0);    // R5 full turn
      run_vec(6, 17, 16'h1234, 1'b1);    // R6 full ring turn
      run_vec(7, 1, 16'h0001, 1'b1);     // R6 carry into MSB
      run_vec(6, 1, 16'h8000, 1'b0);     // R6 zero result, carry out
      run_vec(0, -3, 16'h00F0, 1'b0);    // R7 reversed left
      run_vec(3, -1, 16'h4000, 1'b0);    // R7 reversed arith right
      run_vec(1, 0, 16'hA5A5, 1'b1);     // R8 zero amplitude
      run_vec(6, 0, 16'h0000, 1'b1);     // R8 carry kept
      run_vec(0, 16, 16'h0001, 1'b0);    // R9 exactly W
      run_vec(1, 17, 16'hFFFF, 1'b1);    // R9 beyond W
      run_vec(3, -32, 16'h8000, 1'b0);   // R9/R7 most negative
      run_vec(3, 31, 16'h8000, 1'b0);    // R9 arith saturate

      // Idle cycle: outputs hold (R11).
      held = result;
      @(negedge clk);
      in_valid = 1'b0;
      operand  = ~operand;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== held) begin
         errors++;
         $display("FAIL R11 idle: got v=%b r=%h, expected v=0 r=%h",
                  out_valid, result, held);
      end

      // Constrained random stimulus.
      void'($urandom(32'd20240611));
      for (int n = 0; n < 3000; n++) begin
         int ropc;
         int ramt;
         logic [W-1:0] rx;
         ropc = int'($urandom_range(7, 0));
         ramt = int'($urandom_range(63, 0)) - 32;
         case ($urandom_range(3, 0))
            0:       rx = W'(1) << $urandom_range(W-1, 0);
            1:       rx = ~(W'(1) << $urandom_range(W-1, 0));
            default: rx = W'($urandom);
         endcase
         run_vec(ropc, ramt, rx, 1'($urandom));
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(200000 * 5);
            checks++;
            errors++;
            $display("FAIL R11 watchdog: got timeout, expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule